// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Command Engine

This block lets a processor reach a one-time-programmable fuse array through a small register port. Software stages a command code, a row address and one or two 32-bit data words. It then writes a one to the start register. If processor access is enabled and the engine is idle, the engine takes a snapshot of the staged values and runs the command. Status bit 1 (done) rises when the command completes. Software acknowledges the completion by writing zero to the start register.

The fuse array here is a behavioural model that clears to all zeros at reset. A row holds `ROW_WORDS` words of 32 bits. Programming can only turn fuse bits from zero to one. Writing fuses is locked by default. A key sequence of four program-enable commands unlocks it, and status bit 2 reports the unlocked state. Read and control commands take a fixed number of cycles. A program command takes a base number of cycles plus a fixed cost for every bit that is set to one.

Top module: `otpc_engine`

## Requirements
- R1: Register offsets are: mode 0x00, command 0x04, start 0x08, status 0x0c, read word0 0x10, address 0x28, write word0 0x2c, read word1 0x5c, write word1 0x64. Mode keeps only bit 0, command keeps bits 5:0 and address keeps bits 15:0; higher written bits read back as zero. The write words keep all 32 bits. All registers read zero after reset.
- R2: A write of 1 to start bit 0 while mode bit 0 is 0 starts nothing. Done stays clear, and the staged command never executes.
- R3: Done rises exactly L clock edges after the edge that accepted the start write. L is `READ_CYC` for read (0x00). For program (0x08) while unlocked, L is `PROG_BASE + PROG_PER_BIT * ones`, where ones counts the set bits in the staged row. Every other command, and a locked program, takes `CTRL_CYC`. A start write that arrives while a command is running is ignored.
- R4: Writing 0 to start bit 0 clears done. An accepted start also clears done in its own cycle.
- R5: A read command copies the row at index (address mod `DEPTH`) into the read word registers when it completes. Word0 is row bits 31:0 and word1 is row bits 63:32.
- R6: A program command issued while unlocked ORs the staged write words into the addressed row. Stored bits never return to zero.
- R7: Four program-enable commands (0x02) in a row, whose write word0 values are 0xF, 0x4, 0x8 and 0xD, set status bit 2. A wrong value, or any other command, restarts the key sequence.
- R8: Program-disable (0x03) clears status bit 2. A program command issued while locked still sets done, but leaves the array unchanged.
- R9: Command, address and data are captured when the start is accepted. Register writes made during a running command do not affect it.
- R10: A command code other than 0x00, 0x02, 0x03 or 0x08 completes after `CTRL_CYC` cycles. It changes neither the array nor status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | BUS_AW (8) | Byte offset of the register being written or read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |

## Verification
The bench builds the block with `ROW_WORDS = 2` and `DEPTH = 8`, which reaches both the second-word registers and address aliasing above index 7. It uses `READ_CYC = 2`, `CTRL_CYC = 3`, `PROG_BASE = 4` and `PROG_PER_BIT = 1`, which keep every latency distinct. With these values a program of all ones across both words takes 68 cycles, the slowest case. A small popcount gives a short but clearly different latency.

// File: rtl/otpc_pkg.sv
// Package: shared register offsets, command codes and the unlock key for the
// fuse controller engine. Assumes a 32-bit register data path.
package otpc_pkg;
    localparam int WORD_W     = 32;
    localparam int CMD_W      = 6;
    localparam int ADR_W      = 16;
    localparam int UNLOCK_LEN = 4;
    localparam int STEP_W     = $clog2(UNLOCK_LEN);

    localparam logic [CMD_W-1:0] CMD_READ = 6'h00;
    localparam logic [CMD_W-1:0] CMD_PEN  = 6'h02;
    localparam logic [CMD_W-1:0] CMD_PDIS = 6'h03;
    localparam logic [CMD_W-1:0] CMD_PROG = 6'h08;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_START = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0c;
    localparam logic [7:0] OFS_RD0   = 8'h10;
    localparam logic [7:0] OFS_ADDR  = 8'h28;
    localparam logic [7:0] OFS_WD0   = 8'h2c;
    localparam logic [7:0] OFS_RD1   = 8'h5c;
    localparam logic [7:0] OFS_WD1   = 8'h64;

    localparam int STAT_DONE_BIT = 1;
    localparam int STAT_OK_BIT   = 2;

    // Expected data word for each step of the unlock sequence.
    function automatic logic [WORD_W-1:0] unlock_key(input logic [STEP_W-1:0] step);
        case (step)
            2'd0:    return 32'h0000_000f;
            2'd1:    return 32'h0000_0004;
            2'd2:    return 32'h0000_0008;
            default: return 32'h0000_000d;
        endcase
    endfunction

    // Offset of staged write word k.
    function automatic logic [7:0] wd_ofs(input int k);
        return (k == 0) ? OFS_WD0 : OFS_WD1;
    endfunction

    // Offset of read result word k.
    function automatic logic [7:0] rd_ofs(input int k);
        return (k == 0) ? OFS_RD0 : OFS_RD1;
    endfunction
endpackage

// File: rtl/otpc_unlock.sv
// Unlock tracker: follows completed commands and grants programming after the
// four-word key has arrived through consecutive program-enable commands.
// Assumes cmd_done is a single-cycle pulse carrying the finished command.
module otpc_unlock
    import otpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [WORD_W-1:0] key_word,
    output logic              unlocked
);
    logic [STEP_W-1:0] step_q;
    logic              key_hit;

    assign key_hit = (key_word == unlock_key(step_q));

    // Advance, restart or finish the key sequence on each completed command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            unlocked <= 1'b0;
        end else if (cmd_done) begin
            if (cmd == CMD_PEN) begin
                if (!key_hit) begin
                    step_q <= '0;
                end else if (step_q == STEP_W'(UNLOCK_LEN - 1)) begin
                    step_q   <= '0;
                    unlocked <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else begin
                step_q <= '0;
                if (cmd == CMD_PDIS) unlocked <= 1'b0;
            end
        end
    end

    // R8: a completed disable leaves programming locked.
    a_r8_disable_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd == CMD_PDIS) |=> !unlocked);

    // R7: the unlock grant only rises at the completion of an enable command.
    a_r7_grant_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(cmd_done && cmd == CMD_PEN));
endmodule

// File: rtl/otpc_sequencer.sv
// Command sequencer: on launch it loads the latency for the command and counts
// it down. It then gives a one-cycle finish pulse. Assumes launch arrives only
// while idle, and that every latency parameter is at least 1.
module otpc_sequencer
    import otpc_pkg::*;
#(
    parameter int ROW_W        = 64,
    parameter int READ_CYC     = 2,
    parameter int CTRL_CYC     = 3,
    parameter int PROG_BASE    = 4,
    parameter int PROG_PER_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CMD_W-1:0] cmd,
    input  logic             prog_allowed,
    input  logic [ROW_W-1:0] row_data,
    output logic             busy,
    output logic             finish
);
    localparam int MAX_LAT = PROG_BASE + PROG_PER_BIT * ROW_W + READ_CYC + CTRL_CYC;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ones;
    logic [CNT_W-1:0] lat;

    // Count the fuse bits that the row data would set.
    always_comb begin
        ones = '0;
        for (int i = 0; i < ROW_W; i++) ones = ones + CNT_W'(row_data[i]);
    end

    // Pick the latency for the command being launched.
    always_comb begin
        case (cmd)
            CMD_READ: lat = CNT_W'(READ_CYC);
            CMD_PROG: lat = prog_allowed ? CNT_W'(PROG_BASE) + CNT_W'(PROG_PER_BIT) * ones
                                         : CNT_W'(CTRL_CYC);
            default:  lat = CNT_W'(CTRL_CYC);
        endcase
    end

    assign finish = busy && (cnt_q == CNT_W'(1));

    // Busy flag and countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (launch) begin
            busy  <= 1'b1;
            cnt_q <= lat;
        end else if (busy) begin
            if (finish) busy <= 1'b0;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3: a running command always has cycles left to count.
    a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));

    // R3: the engine stays busy until its finish pulse.
    a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);
endmodule

// File: rtl/otpc_fuse_array.sv
// Behavioural fuse array: DEPTH rows of ROW_W bits. All rows are clear at reset,
// and programming ORs the new bits in. Assumes DEPTH is a power of two of at least 2.
module otpc_fuse_array #(
    parameter int DEPTH = 16,
    parameter int ROW_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [ROW_W-1:0]         prog_row,
    output logic [ROW_W-1:0]         rd_row
);
    logic [ROW_W-1:0] mem [DEPTH];

    // Clear on reset; otherwise add the programmed bits to the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (prog_we) begin
            mem[idx] <= mem[idx] | prog_row;
        end
    end

    assign rd_row = mem[idx];

    // R6: a stored fuse bit never returns to zero.
    for (genvar g = 0; g < DEPTH; g++) begin : g_mono
        a_r6_fuse_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
            ((mem[g] & $past(mem[g])) == $past(mem[g])));
    end
endmodule

// File: rtl/otpc_engine.sv
// Fuse controller top. It holds the register file, accepts start writes,
// captures the operands and returns results and status. Assumes only one
// register write per cycle and combinational register reads.
module otpc_engine
    import otpc_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int ROW_WORDS    = 2,
    parameter int READ_CYC     = 2,
    parameter int CTRL_CYC     = 3,
    parameter int PROG_BASE    = 4,
    parameter int PROG_PER_BIT = 1,
    parameter int BUS_AW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam int ROW_W = ROW_WORDS * WORD_W;
    localparam int IDX_W = $clog2(DEPTH);

    logic              mode_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [ADR_W-1:0]  addr_q;
    logic [WORD_W-1:0] wd_q [ROW_WORDS];
    logic [WORD_W-1:0] rd_q [ROW_WORDS];
    logic [ROW_W-1:0]  wd_row;
    logic              done_q;

    logic [CMD_W-1:0]  op_cmd_q;
    logic [IDX_W-1:0]  op_idx_q;
    logic [ROW_W-1:0]  op_row_q;
    logic              op_prog_q;

    logic              busy, finish, unlocked, prog_we;
    logic              start_wr, launch, ack;
    logic [ROW_W-1:0]  arr_row;

    assign start_wr = reg_we && (reg_addr == BUS_AW'(OFS_START));
    assign launch   = start_wr && reg_wdata[0] && mode_q && !busy;
    assign ack      = start_wr && !reg_wdata[0];
    assign prog_we  = finish && (op_cmd_q == CMD_PROG) && op_prog_q;

    // Control registers: mode, command and address, trimmed to their widths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            cmd_q  <= '0;
            addr_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == BUS_AW'(OFS_MODE)) mode_q <= reg_wdata[0];
            if (reg_addr == BUS_AW'(OFS_CMD))  cmd_q  <= reg_wdata[CMD_W-1:0];
            if (reg_addr == BUS_AW'(OFS_ADDR)) addr_q <= reg_wdata[ADR_W-1:0];
        end
    end

    for (genvar k = 0; k < ROW_WORDS; k++) begin : g_word
        // Staged write word k.
        always_ff @(posedge clk) begin
            if (!rst_n) wd_q[k] <= '0;
            else if (reg_we && reg_addr == BUS_AW'(wd_ofs(k))) wd_q[k] <= reg_wdata;
        end
        // Read result word k, loaded when a read completes.
        always_ff @(posedge clk) begin
            if (!rst_n) rd_q[k] <= '0;
            else if (finish && op_cmd_q == CMD_READ) rd_q[k] <= arr_row[k*WORD_W +: WORD_W];
        end
        assign wd_row[k*WORD_W +: WORD_W] = wd_q[k];
    end

    // Operand snapshot taken when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_cmd_q  <= '0;
            op_idx_q  <= '0;
            op_row_q  <= '0;
            op_prog_q <= 1'b0;
        end else if (launch) begin
            op_cmd_q  <= cmd_q;
            op_idx_q  <= addr_q[IDX_W-1:0];
            op_row_q  <= wd_row;
            op_prog_q <= unlocked;
        end
    end

    // Done flag: cleared on launch, set on finish, cleared by writing start as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (launch) done_q <= 1'b0;
        else if (finish) done_q <= 1'b1;
        else if (ack)    done_q <= 1'b0;
    end

    otpc_sequencer #(
        .ROW_W(ROW_W), .READ_CYC(READ_CYC), .CTRL_CYC(CTRL_CYC),
        .PROG_BASE(PROG_BASE), .PROG_PER_BIT(PROG_PER_BIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd_q),
        .prog_allowed(unlocked), .row_data(wd_row), .busy(busy), .finish(finish)
    );

    otpc_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .cmd_done(finish), .cmd(op_cmd_q),
        .key_word(op_row_q[WORD_W-1:0]), .unlocked(unlocked)
    );

    otpc_fuse_array #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_array (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .idx(op_idx_q),
        .prog_row(op_row_q), .rd_row(arr_row)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == BUS_AW'(OFS_MODE)) reg_rdata[0] = mode_q;
        if (reg_addr == BUS_AW'(OFS_CMD))  reg_rdata[CMD_W-1:0] = cmd_q;
        if (reg_addr == BUS_AW'(OFS_ADDR)) reg_rdata[ADR_W-1:0] = addr_q;
        if (reg_addr == BUS_AW'(OFS_STAT)) begin
            reg_rdata[STAT_DONE_BIT] = done_q;
            reg_rdata[STAT_OK_BIT]   = unlocked;
        end
        for (int k = 0; k < ROW_WORDS; k++) begin
            if (reg_addr == BUS_AW'(wd_ofs(k))) reg_rdata = wd_q[k];
            if (reg_addr == BUS_AW'(rd_ofs(k))) reg_rdata = rd_q[k];
        end
    end

    // R4: every finish pulse leaves done set.
    a_r4_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_q);

    // R2: a start issued with access off leaves the engine idle.
    a_r2_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && reg_wdata[0] && !mode_q && !busy) |=> !busy);

    // R8: the array is written only while programming is unlocked.
    a_r8_prog_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> unlocked);
endmodule

// File: tb/tb_otpc_engine.sv
// Self-checking bench: a behavioural model of the register behaviour is
// updated on every clock and compared with the read port. Directed sequences
// check latency, unlock, programming and aliasing.
module tb_otpc_engine;
    localparam int DEPTH = 8;
    localparam int RW    = 2;
    localparam int RDC   = 2;
    localparam int CTC   = 3;
    localparam int PB    = 4;
    localparam int PPB   = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit reported = 0;

    otpc_engine #(.DEPTH(DEPTH), .ROW_WORDS(RW), .READ_CYC(RDC), .CTRL_CYC(CTC),
                  .PROG_BASE(PB), .PROG_PER_BIT(PPB), .BUS_AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #4 clk = ~clk;

    // ---------------- behavioural model ----------------
    bit          m_mode, m_done, m_ok, m_busy, m_prog;
    bit   [5:0]  m_cmd, m_op_cmd;
    bit   [15:0] m_addr;
    bit   [31:0] m_wd [2];
    bit   [31:0] m_rd [2];
    bit   [31:0] m_op [2];
    bit   [31:0] m_arr [DEPTH][2];
    int          m_rem, m_step, m_idx;
    bit          b0, md0, fin;
    bit   [31:0] keys [4] = '{32'hf, 32'h4, 32'h8, 32'hd};

    function automatic int pop(input bit [31:0] a, input bit [31:0] b);
        int n = 0;
        for (int i = 0; i < 32; i++) n += a[i] + b[i];
        return n;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_mode = 0; m_done = 0; m_ok = 0; m_busy = 0; m_prog = 0;
            m_cmd = 0; m_op_cmd = 0; m_addr = 0; m_rem = 0; m_step = 0; m_idx = 0;
            for (int k = 0; k < 2; k++) begin m_wd[k] = 0; m_rd[k] = 0; m_op[k] = 0; end
            for (int r = 0; r < DEPTH; r++) begin m_arr[r][0] = 0; m_arr[r][1] = 0; end
        end else begin
            b0 = m_busy; md0 = m_mode; fin = m_busy && m_rem == 1;
            if (m_busy) begin
                if (m_rem == 1) begin
                    m_busy = 0; m_done = 1;
                    if (m_op_cmd == 6'h00) begin
                        m_rd[0] = m_arr[m_idx][0]; m_rd[1] = m_arr[m_idx][1];
                    end
                    if (m_op_cmd == 6'h08 && m_prog) begin
                        m_arr[m_idx][0] |= m_op[0]; m_arr[m_idx][1] |= m_op[1];
                    end
                    if (m_op_cmd == 6'h02) begin
                        if (m_op[0] != keys[m_step]) m_step = 0;
                        else if (m_step == 3) begin m_step = 0; m_ok = 1; end
                        else m_step++;
                    end else begin
                        m_step = 0;
                        if (m_op_cmd == 6'h03) m_ok = 0;
                    end
                end else m_rem--;
            end
            if (reg_we) begin
                case (reg_addr)
                    8'h00: m_mode = reg_wdata[0];
                    8'h04: m_cmd = reg_wdata[5:0];
                    8'h28: m_addr = reg_wdata[15:0];
                    8'h2c: m_wd[0] = reg_wdata;
                    8'h64: m_wd[1] = reg_wdata;
                    8'h08: begin
                        if (reg_wdata[0]) begin
                            if (md0 && !b0) begin
                                m_busy = 1; m_done = 0;
                                m_op_cmd = m_cmd; m_idx = m_addr % DEPTH;
                                m_op[0] = m_wd[0]; m_op[1] = m_wd[1]; m_prog = m_ok;
                                if (m_cmd == 6'h00) m_rem = RDC;
                                else if (m_cmd == 6'h08 && m_ok) m_rem = PB + PPB * pop(m_wd[0], m_wd[1]);
                                else m_rem = CTC;
                            end
                        end else if (!fin) m_done = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic bit [31:0] m_read(input bit [7:0] a);
        case (a)
            8'h00: return {31'b0, m_mode};
            8'h04: return {26'b0, m_cmd};
            8'h0c: return {29'b0, m_ok, m_done, 1'b0};
            8'h10: return m_rd[0];
            8'h28: return {16'b0, m_addr};
            8'h2c: return m_wd[0];
            8'h5c: return m_rd[1];
            8'h64: return m_wd[1];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input bit [7:0] a);
        if (a == 8'h0c) return "R4";
        if (a == 8'h10 || a == 8'h5c) return "R5";
        return "R1";
    endfunction

    // Compare the read port with the model on every clock.
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            checks++;
            if (reg_rdata !== m_read(reg_addr)) begin
                errors++;
                $display("FAIL %s model compare @%0h: actual %h expected %h",
                         tag_of(reg_addr), reg_addr, reg_rdata, m_read(reg_addr));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rdv(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); reg_we = 1'b0; reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic wait_done(input int c0, output int lat, output logic [31:0] st);
        lat = -1;
        for (int n = 0; n < 300; n++) begin
            rdv(8'h0c, st);
            if (st[1]) begin lat = cyc - c0; break; end
        end
    endtask

    task automatic run(input int exp_lat, input string tag, output logic [31:0] st);
        int c0, lat;
        wr(8'h08, 32'h1);
        c0 = cyc;
        wait_done(c0, lat, st);
        chk(tag, lat, exp_lat);
        wr(8'h08, 32'h0);
    endtask

    task automatic read_row(input logic [15:0] a, output logic [31:0] w0, output logic [31:0] w1);
        logic [31:0] st;
        wr(8'h04, 32'h0);
        wr(8'h28, {16'h0, a});
        run(RDC, "R3 read latency", st);
        rdv(8'h10, w0);
        rdv(8'h5c, w1);
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, w0, w1, st;
        int c0, lat;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdv(8'h00, v); chk("R1 reset mode", v, 0);
        rdv(8'h0c, v); chk("R1 reset status", v, 0);
        rdv(8'h10, v); chk("R1 reset read word0", v, 0);

        // R2 start with access off is ignored
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h1);
        repeat (8) @(negedge clk);
        rdv(8'h0c, v); chk("R2 no done with mode off", v, 0);
        wr(8'h08, 32'h0);

        // R1 field widths
        wr(8'h04, 32'hFF);       rdv(8'h04, v); chk("R1 command trimmed", v, 32'h3F);
        wr(8'h28, 32'h12345);    rdv(8'h28, v); chk("R1 address trimmed", v, 32'h2345);
        wr(8'h2c, 32'hDEADBEEF); rdv(8'h2c, v); chk("R1 write word0", v, 32'hDEADBEEF);
        wr(8'h64, 32'hCAFE0001); rdv(8'h64, v); chk("R1 write word1", v, 32'hCAFE0001);
        wr(8'h00, 32'hFFFF);     rdv(8'h00, v); chk("R1 mode trimmed", v, 32'h1);

        // R5 read blank row, R3 read latency
        read_row(16'h3, w0, w1);
        chk("R5 blank row word0", w0, 0);

        // R8 locked program completes, no change; R4 clear done
        wr(8'h04, 32'h08); wr(8'h28, 32'h3); wr(8'h2c, 32'hFF); wr(8'h64, 32'h0);
        run(CTC, "R8 locked program latency", st);
        chk("R8 locked program status", st, 32'h2);
        rdv(8'h0c, v); chk("R4 start zero clears done", v, 0);
        read_row(16'h3, w0, w1);
        chk("R8 locked program leaves row", w0, 0);

        // R7 unlock with a broken attempt first
        wr(8'h04, 32'h02);
        wr(8'h2c, 32'hF); run(CTC, "R3 control latency", st);
        wr(8'h2c, 32'h4); run(CTC, "R7 step", st);
        wr(8'h2c, 32'h5); run(CTC, "R7 step", st);
        chk("R7 wrong key keeps lock", st, 32'h2);
        wr(8'h2c, 32'hF); run(CTC, "R7 step", st);
        wr(8'h2c, 32'h4); run(CTC, "R7 step", st);
        wr(8'h2c, 32'h8); run(CTC, "R7 step", st);
        wr(8'h2c, 32'hD); run(CTC, "R7 step", st);
        chk("R7 full key unlocks", st, 32'h6);

        // R6 program with OR, R3 popcount latency
        wr(8'h04, 32'h08); wr(8'h28, 32'h3);
        wr(8'h2c, 32'hF0); wr(8'h64, 32'h1);
        run(PB + PPB * 5, "R3 program latency five bits", st);
        wr(8'h2c, 32'h0F); wr(8'h64, 32'h0);
        wr(8'h04, 32'h08); wr(8'h28, 32'h3);
        run(PB + PPB * 4, "R3 program latency four bits", st);
        read_row(16'h3, w0, w1);
        chk("R6 OR word0", w0, 32'hFF);
        chk("R6 OR word1", w1, 32'h1);

        // R3 slowest case: all ones on both words
        wr(8'h04, 32'h08); wr(8'h28, 32'h5);
        wr(8'h2c, 32'hFFFFFFFF); wr(8'h64, 32'hFFFFFFFF);
        run(PB + PPB * 64, "R3 program latency all ones", st);
        read_row(16'h5, w0, w1);
        chk("R6 all ones word1", w1, 32'hFFFFFFFF);

        // R5 address aliasing: 0xB maps to row 3
        read_row(16'hB, w0, w1);
        chk("R5 alias word0", w0, 32'hFF);
        chk("R5 alias word1", w1, 32'h1);

        // R9 and R3: writes and a second start during busy
        wr(8'h04, 32'h08); wr(8'h28, 32'h6);
        wr(8'h2c, 32'hFF); wr(8'h64, 32'h0);
        wr(8'h08, 32'h1);
        c0 = cyc;
        wr(8'h2c, 32'hFFFF);
        wr(8'h28, 32'h2);
        wr(8'h08, 32'h1);
        wait_done(c0, lat, st);
        chk("R3 start during busy ignored", lat, PB + PPB * 8);
        wr(8'h08, 32'h0);
        read_row(16'h6, w0, w1);
        chk("R9 snapshot data used", w0, 32'hFF);
        read_row(16'h2, w0, w1);
        chk("R9 snapshot address used", w0, 0);

        // R4 launch clears done
        wr(8'h28, 32'h6);
        run(RDC, "R3 read latency", st);
        wr(8'h08, 32'h1);
        rdv(8'h0c, v); wr(8'h08, 32'h0);
        chk("R4 status idle", v, 32'h4);
        wr(8'h08, 32'h1);
        c0 = cyc;
        rdv(8'h0c, v); chk("R4 launch clears done", v, 32'h4);
        wait_done(c0, lat, st);
        wr(8'h08, 32'h0);

        // R10 unknown command
        wr(8'h04, 32'h3F); wr(8'h28, 32'h3); wr(8'h2c, 32'hFFFFFFFF);
        run(CTC, "R10 unknown latency", st);
        chk("R10 unknown keeps unlock", st, 32'h6);
        read_row(16'h3, w0, w1);
        chk("R10 unknown leaves row", w0, 32'hFF);

        // R8 disable, then locked program
        wr(8'h04, 32'h03);
        run(CTC, "R8 disable latency", st);
        chk("R8 disable clears ok", st, 32'h2);
        wr(8'h04, 32'h08); wr(8'h28, 32'h0); wr(8'h2c, 32'h1);
        run(CTC, "R8 relocked program latency", st);
        read_row(16'h0, w0, w1);
        chk("R8 relocked program leaves row", w0, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule